// File: doc/BRIEF.md
# Input Change Interrupt Generator

This block raises the interrupt request of a 16-pin general-purpose I/O expander. The pins are grouped into ports of eight. For every pin it compares the synchronised pin level with the value held in that port's input register. Only pins whose direction bit selects input take part in this comparison. A port starts to request an interrupt when the set of differing input pins changes to a non-empty set.

A port stops requesting in either of two cases. The first is that all of its input pins match their held values again. The second is that the system reads that port's input register, signalled by a one-cycle read strobe.

The per-port requests are ORed into a single flag. That flag is the pull-down enable of an active-low, open-drain interrupt line: 1 means the line is pulled low. The input registers themselves live outside the block and arrive on `latch_val_i`.

Top module: `pin_change_irq`

## Requirements
- R1: When an input-direction pin (direction bit 1) changes away from its held value, `irq_pull_o` goes to 1 on the third rising clock edge after the change.
- R2: A pin whose direction bit is 0 (output) never causes `irq_pull_o` to be 1, whatever its level.
- R3: When every changed input pin of a port returns to its held value, that port's request ends on the third rising edge after the return.
- R4: A one-cycle pulse on `port_rd_i[p]` ends port p's request at the next rising edge. The request stays ended while the set of differing pins stays the same.
- R5: A read strobe for one port does not end a request held by the other port. Bit 0 covers pins 7..0 and bit 1 covers pins 15..8.
- R6: Switching a pin's direction bit from 0 to 1 while its level differs from its held value sets `irq_pull_o` at the next rising edge.
- R7: Pin levels pass through a two-stage synchroniser, so `irq_pull_o` is still 0 two rising edges after a pin change.
- R8: While `rst_n` is low, and after reset until a mismatch appears, `irq_pull_o` is 0.
- R9: After a read has ended a request, a further change in that port's set of differing input pins raises the request again.
- R10: `irq_pull_o` is 1 while either port holds a request; it is 0 only when neither does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | 16 | Raw pin levels, asynchronous to clk |
| dir_in_i | input | 16 | Direction per pin, 1 = input, 0 = output |
| latch_val_i | input | 16 | Current contents of the two input registers |
| port_rd_i | input | 2 | One-cycle read strobe per port input register |
| irq_pull_o | output | 1 | Pull-down enable of the active-low interrupt line |

## Verification
The bench applies single-pin flips, returns to the held level, and second flips after a read. These separate an interrupt that follows the live mismatch from one that stays set after a read. The same flip is then applied to a pin set as output, and that pin's direction is switched afterwards. This shows that masking is applied at comparison time and not at pin-change time. Simultaneous flips in both ports, read one port at a time, show whether the strobes act per port or together. Checks at the second and third edge after a flip pin down the synchroniser depth.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
   // Default geometry of the expander
   parameter int unsigned DEF_PORT_W  = 8;
   parameter int unsigned DEF_PORTS   = 2;
   parameter int unsigned DEF_SYNC_N  = 2;

   // Reset level of synchroniser flops
   parameter logic SYNC_RST_LVL = 1'b0;
endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
   parameter int unsigned WIDTH   = 16,
   parameter int unsigned STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   import pcirq_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("pcirq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pcirq_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= {WIDTH{SYNC_RST_LVL}};
         end else if (s == 0) begin
            chain[s] <= d_i;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pcirq_port_tracker.sv
module pcirq_port_tracker #(
   parameter int unsigned PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] lvl_s_i,
   input  logic [PORT_W-1:0] dir_in_i,
   input  logic [PORT_W-1:0] held_i,
   input  logic              rd_i,
   output logic              req_o,
   output logic              diff_any_o
);
   if (PORT_W < 1) begin : g_bad_w
      $error("pcirq_port_tracker: PORT_W must be positive");
   end

   logic [PORT_W-1:0] diff_now;
   logic [PORT_W-1:0] diff_last;
   logic              req_q;

   // Only input-direction pins may disagree with the held value
   assign diff_now   = dir_in_i & (lvl_s_i ^ held_i);
   assign diff_any_o = |diff_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q     <= 1'b0;
         diff_last <= '0;
      end else begin
         diff_last <= diff_now;
         if (rd_i) begin
            req_q <= 1'b0;
         end else if (diff_now == '0) begin
            req_q <= 1'b0;
         end else if (diff_now != diff_last) begin
            req_q <= 1'b1;
         end
      end
   end

   assign req_o = req_q;

   // R4: a read strobe ends the request at the next edge
   a_r4_read_ends_req : assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> !req_o);

   // R3: no differing input pin means no request one edge later
   a_r3_match_ends_req : assert property (@(posedge clk) disable iff (!rst_n)
      !diff_any_o |=> !req_o);

   // R2: a request only starts from a real input-pin difference
   a_r2_only_inputs : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(diff_any_o) && !$past(rd_i));
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
   parameter int unsigned PORT_W  = pcirq_pkg::DEF_PORT_W,
   parameter int unsigned PORTS   = pcirq_pkg::DEF_PORTS,
   parameter int unsigned SYNC_N  = pcirq_pkg::DEF_SYNC_N,
   localparam int unsigned NPIN   = PORT_W * PORTS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_lvl_i,
   input  logic [NPIN-1:0] dir_in_i,
   input  logic [NPIN-1:0] latch_val_i,
   input  logic [PORTS-1:0] port_rd_i,
   output logic            irq_pull_o
);
   if (PORTS < 1) begin : g_bad_ports
      $error("pin_change_irq: PORTS must be positive");
   end

   logic [NPIN-1:0]  lvl_s;
   logic [PORTS-1:0] port_req;
   logic [PORTS-1:0] port_diff;

   pcirq_sync #(.WIDTH(NPIN), .STAGES(SYNC_N)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_lvl_i),
      .q_o   (lvl_s)
   );

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      pcirq_port_tracker #(.PORT_W(PORT_W)) u_trk (
         .clk        (clk),
         .rst_n      (rst_n),
         .lvl_s_i    (lvl_s[p*PORT_W +: PORT_W]),
         .dir_in_i   (dir_in_i[p*PORT_W +: PORT_W]),
         .held_i     (latch_val_i[p*PORT_W +: PORT_W]),
         .rd_i       (port_rd_i[p]),
         .req_o      (port_req[p]),
         .diff_any_o (port_diff[p])
      );
   end

   // R10: any port request pulls the shared line low
   assign irq_pull_o = |port_req;

   // R10: the line only releases after a read or a full match
   a_r10_release_cause : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_pull_o) |-> ($past(|port_rd_i) || !$past(&port_diff)));

   // R8: line stays released unless some port saw a difference
   a_r8_quiet_without_diff : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(port_diff) == '0 && !$past(irq_pull_o)) |-> !irq_pull_o);
endmodule

// File: tb/sim_pin_change_irq.sv
module sim_pin_change_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pin_lvl_i;
   logic [15:0] dir_in_i;
   logic [15:0] latch_val_i;
   logic [1:0]  port_rd_i;
   logic        irq_pull_o;

   localparam logic [15:0] HELD = 16'h3C5A;

   always #10 clk = ~clk;

   pin_change_irq u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_lvl_i   (pin_lvl_i),
      .dir_in_i    (dir_in_i),
      .latch_val_i (latch_val_i),
      .port_rd_i   (port_rd_i),
      .irq_pull_o  (irq_pull_o)
   );

   typedef struct { logic exp; string tag; } item_t;
   item_t sb_q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Monitor: pops expectations at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (irq_pull_o !== it.exp) begin
               n_bad++;
               $display("FAIL %s: irq_pull_o=%b expected %b", it.tag, irq_pull_o, it.exp);
            end
         end
      end
   end

   // Driver helpers
   task automatic edges(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic expect_irq(input logic e, input string tag);
      item_t it;
      it.exp = e;
      it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic strobe(input logic [1:0] r);
      port_rd_i = r;
      @(posedge clk);
      #1;
      port_rd_i = 2'b00;
   endtask

   initial begin : watchdog
      repeat (10000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      pin_lvl_i   = HELD;
      latch_val_i = HELD;
      dir_in_i    = 16'h0000;
      port_rd_i   = 2'b00;
      edges(3);
      #1;
      expect_irq(1'b0, "R8 during reset");
      rst_n = 1'b1;
      edges(3);
      #1;
      dir_in_i = 16'hFFFF;
      edges(3);
      expect_irq(1'b0, "R8 matched inputs after reset");

      // R7 / R1: flip pin 3
      pin_lvl_i[3] = ~pin_lvl_i[3];
      edges(2);
      expect_irq(1'b0, "R7 two edges after change");
      pin_lvl_i = pin_lvl_i;
      // one more edge reaches the third
      sb_q.push_back('{exp: 1'b1, tag: "R1 third edge after change"});
      @(negedge clk); #1;

      // R3: return
      pin_lvl_i[3] = HELD[3];
      edges(2);
      expect_irq(1'b1, "R3 still set two edges after return");
      sb_q.push_back('{exp: 1'b0, tag: "R3 cleared after return"});
      @(negedge clk); #1;

      // R5 / R4: flip again, read other port, then own port
      pin_lvl_i[3] = ~HELD[3];
      edges(3);
      expect_irq(1'b1, "R1 second flip");
      strobe(2'b10);
      expect_irq(1'b1, "R5 port1 read keeps port0 request");
      strobe(2'b01);
      expect_irq(1'b0, "R4 port0 read clears");
      edges(2);
      expect_irq(1'b0, "R4 stays clear with same difference");

      // R9: further change in port 0
      pin_lvl_i[5] = ~HELD[5];
      edges(3);
      expect_irq(1'b1, "R9 new difference after read");
      strobe(2'b01);
      expect_irq(1'b0, "R4 second read clears");
      pin_lvl_i[3] = HELD[3];
      pin_lvl_i[5] = HELD[5];
      edges(4);
      expect_irq(1'b0, "R3 restore after read");

      // R2: output pin flips
      dir_in_i[10] = 1'b0;
      pin_lvl_i[10] = ~HELD[10];
      edges(5);
      expect_irq(1'b0, "R2 output pin masked");

      // R6: becomes input with mismatch
      dir_in_i[10] = 1'b1;
      edges(1);
      expect_irq(1'b1, "R6 direction switch raises");
      strobe(2'b10);
      expect_irq(1'b0, "R4 port1 read clears");
      pin_lvl_i[10] = HELD[10];
      edges(4);
      expect_irq(1'b0, "R3 port1 restored");

      // R10: both ports
      pin_lvl_i[1]  = ~HELD[1];
      pin_lvl_i[12] = ~HELD[12];
      edges(3);
      expect_irq(1'b1, "R10 both ports request");
      strobe(2'b01);
      expect_irq(1'b1, "R10 port1 still holds line");
      strobe(2'b10);
      expect_irq(1'b0, "R10 neither port requests");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule